// File: doc/BRIEF.md
# Three-Wire Serial Programming Register Bank

This block receives configuration words from a host over three wires (a serial clock, a data line and an enable line) and holds them in five configuration registers that steer a radio front end. The three serial inputs are brought into the system clock domain through a synchronizer chain. Each rising edge of the serial clock shifts one data bit in, most significant bit first. A frame is the run of bits shifted in while the enable line stays at one level, and it closes when the enable line changes level.

The enable level picks the register space. A frame that closes with enable low must be 16 bits long. Its two leading bits pick one of four registers: the control word, the receive loop divider, the reference divider with its post-divide select, or the transmit loop divider. A frame that closes with enable high writes the oscillator trim and battery threshold register. It may be 12 or 16 bits long: the first bit must be 1, then come one or five filler bits, then the four threshold bits and the six trim bits. A frame of any other length is dropped. The block also decodes the threshold code into millivolts, and it routes one of five status sources to a shared status output according to the control word.

Top module: `serial_prog_bank`

## Requirements
- R1: After reset the receive ratio is 7215, the transmit ratio is 9966, the reference ratio is 2048 with post-select 0, all power-off and mute outputs are 0, the trim code is 0 and the threshold code is 0.
- R2: A data bit is taken on each rising serial clock edge and shifted in MSB first. A frame closes when the enable level changes, and the next frame starts empty.
- R3: A 16-bit frame closed with enable low decodes mode = {bit15, bit14}. Mode 00 writes control. Mode 01 sets the receive ratio to bits 13:0. Mode 10 sets the post-select to bits 13:12 and the reference ratio to bits 11:0. Mode 11 sets the transmit ratio to bits 13:0.
- R4: In the control word, bit 13 is transmit loop power-off, bit 12 compressor mute, bit 11 compressor power-off, bit 10 expander mute, bit 9 expander power-off, bit 7 status select, bit 6 battery detector power-off, bit 5 receiver power-off, and bits 1:0 are the test code (bit 1 is its upper bit). All other bits are ignored.
- R5: A frame closed with enable high, 12 or 16 bits long, whose first bit is 1, sets the threshold code to bits 9:6 and the trim code to bits 5:0 of the frame. The filler bits between are ignored.
- R6: A frame closed with enable high whose first bit is 0 changes no register.
- R7: The threshold output in millivolts is 3450 for code 0000, 3300 for 1011, 3000 for 1101, 2200 for 0111, 2100 for 1111, and 3450 for every other code.
- R8: A frame closed with enable low whose length is not 16, or closed with enable high whose length is neither 12 nor 16 (frames longer than 16 included), changes no register.
- R9: The status output follows the test code. Code 00 gives carrier detect when status select is 0 and lock detect when it is 1. Code 01 gives the divided test reference, code 10 the receive loop test signal, and code 11 the transmit loop test signal.
- R10: An accepted frame changes only the register it addresses. All other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_dat | input | 1 | Serial data from host |
| ser_en | input | 1 | Serial enable, selects register space, closes frames on change |
| carrier_det | input | 1 | Carrier detect status source |
| lock_det | input | 1 | Loop lock detect status source |
| ref_test | input | 1 | Divided test reference status source |
| rx_loop_tst | input | 1 | Receive loop test status source |
| tx_loop_tst | input | 1 | Transmit loop test status source |
| rx_ratio | output | 14 | Receive loop divide ratio |
| tx_ratio | output | 14 | Transmit loop divide ratio |
| ref_ratio | output | 12 | Reference divide ratio |
| ref_post_sel | output | 2 | Reference post-divide select |
| tx_pll_off | output | 1 | Transmit loop power-off |
| comp_mute | output | 1 | Compressor mute |
| comp_off | output | 1 | Compressor power-off |
| exp_mute | output | 1 | Expander mute |
| exp_off | output | 1 | Expander power-off |
| batt_off | output | 1 | Battery detector power-off |
| rx_off | output | 1 | Receiver power-off |
| cap_trim | output | 6 | Oscillator capacitor trim code |
| thr_code | output | 4 | Battery threshold code |
| thr_mv | output | 12 | Decoded battery threshold in millivolts |
| status_out | output | 1 | Routed shared status signal |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a five-bit frame counter that saturates at 31, and the reset ratios 7215, 9966 and 2048. With a five-bit counter a 20-bit frame stays distinct from a 16-bit one, so the over-length discard path can be reached. The two-stage synchronizer gives a short, fixed latency from a closing enable edge to the register update. Every frame is followed by a comparison of all outputs against a model built from the requirements, so a write that spills into a neighbouring register is caught on the same frame.

// File: rtl/serial_prog_pkg.sv
package serial_prog_pkg;

    localparam int WORD_W   = 16;
    localparam int SHORT_W  = 12;
    localparam int DIV_W    = 14;
    localparam int REFDIV_W = 12;
    localparam int CAP_W    = 6;
    localparam int THR_W    = 4;
    localparam int MV_W     = 12;

    typedef enum logic [1:0] {
        SP_CTRL = 2'b00,
        SP_RX   = 2'b01,
        SP_REF  = 2'b10,
        SP_TX   = 2'b11
    } space_t;

    typedef struct packed {
        logic       tx_pll_off;
        logic       comp_mute;
        logic       comp_off;
        logic       exp_mute;
        logic       exp_off;
        logic       stat_sel;
        logic       batt_off;
        logic       rx_off;
        logic [1:0] test;
    } ctrl_t;

endpackage

// File: rtl/serial_prog_frontend.sv
// Synchronizes the serial wires, shifts bits MSB first (R2) and reports
// each closed frame with its length and the level it was shifted under.
module serial_prog_frontend
    import serial_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en,
    output logic              frm_vld,
    output logic              frm_hi,
    output logic [CNT_W-1:0]  frm_len,
    output logic [WORD_W-1:0] frm_word
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] ck_sy;
        logic [SYNC_STAGES-1:0] dt_sy;
        logic [SYNC_STAGES-1:0] en_sy;
        logic                   ck_prev;
        logic                   en_prev;
        logic [WORD_W-1:0]      shf;
        logic [CNT_W-1:0]       cnt;
        logic                   vld;
        logic                   hi;
        logic [CNT_W-1:0]       len;
        logic [WORD_W-1:0]      word;
    } fe_t;

    fe_t st_d, st_q;
    logic ck_now, dt_now, en_now;

    always_comb begin
        ck_now = st_q.ck_sy[SYNC_STAGES-1];
        dt_now = st_q.dt_sy[SYNC_STAGES-1];
        en_now = st_q.en_sy[SYNC_STAGES-1];

        st_d         = st_q;
        st_d.ck_sy   = {st_q.ck_sy[SYNC_STAGES-2:0], ser_clk};
        st_d.dt_sy   = {st_q.dt_sy[SYNC_STAGES-2:0], ser_dat};
        st_d.en_sy   = {st_q.en_sy[SYNC_STAGES-2:0], ser_en};
        st_d.ck_prev = ck_now;
        st_d.en_prev = en_now;
        st_d.vld     = 1'b0;

        // Enable level change closes the running frame
        if (en_now != st_q.en_prev) begin
            st_d.vld  = 1'b1;
            st_d.hi   = st_q.en_prev;
            st_d.len  = st_q.cnt;
            st_d.word = st_q.shf;
            st_d.cnt  = '0;
        end

        // Rising serial clock: shift in MSB first, count saturating
        if (ck_now && !st_q.ck_prev) begin
            st_d.shf = {st_q.shf[WORD_W-2:0], dt_now};
            if (st_d.cnt != CNT_MAX) begin
                st_d.cnt = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_vld  = st_q.vld;
    assign frm_hi   = st_q.hi;
    assign frm_len  = st_q.len;
    assign frm_word = st_q.word;

    // R2: a reported frame leaves the counter restarted
    assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.cnt <= CNT_W'(1)));

    // R8: a saturated count holds until the frame is closed
    assert_count_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX) |=> ((st_q.cnt == CNT_MAX) || st_q.vld));

endmodule

// File: rtl/serial_prog_regbank.sv
// Decodes closed frames into the five configuration registers.
module serial_prog_regbank
    import serial_prog_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int RX_DEF  = 7215,
    parameter int TX_DEF  = 9966,
    parameter int REF_DEF = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_vld,
    input  logic                frm_hi,
    input  logic [CNT_W-1:0]    frm_len,
    input  logic [WORD_W-1:0]   frm_word,
    output logic [DIV_W-1:0]    rx_ratio,
    output logic [DIV_W-1:0]    tx_ratio,
    output logic [REFDIV_W-1:0] ref_ratio,
    output logic [1:0]          ref_sel,
    output ctrl_t               ctrl,
    output logic [CAP_W-1:0]    cap_trim,
    output logic [THR_W-1:0]    thr_code
);

    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);
    localparam int CAP_LSB = 0;
    localparam int THR_LSB = CAP_LSB + CAP_W;

    typedef struct packed {
        logic [DIV_W-1:0]    rx;
        logic [DIV_W-1:0]    tx;
        logic [REFDIV_W-1:0] rf;
        logic [1:0]          sel;
        ctrl_t               ctl;
        logic [CAP_W-1:0]    cap;
        logic [THR_W-1:0]    thr;
    } bank_t;

    bank_t bk_d, bk_q;
    logic  lo_ok, hi_len_ok, lead_bit, hi_ok;
    ctrl_t ctl_new;

    always_comb begin
        lo_ok     = frm_vld && !frm_hi && (frm_len == LEN_LONG);
        hi_len_ok = (frm_len == LEN_LONG) || (frm_len == LEN_SHORT);
        lead_bit  = frm_word[4'(frm_len - 1'b1)];
        hi_ok     = frm_vld && frm_hi && hi_len_ok && lead_bit;

        ctl_new.tx_pll_off = frm_word[13];
        ctl_new.comp_mute  = frm_word[12];
        ctl_new.comp_off   = frm_word[11];
        ctl_new.exp_mute   = frm_word[10];
        ctl_new.exp_off    = frm_word[9];
        ctl_new.stat_sel   = frm_word[7];
        ctl_new.batt_off   = frm_word[6];
        ctl_new.rx_off     = frm_word[5];
        ctl_new.test       = frm_word[1:0];

        bk_d = bk_q;
        if (lo_ok) begin
            unique case (space_t'(frm_word[15:14]))
                SP_CTRL: bk_d.ctl = ctl_new;
                SP_RX:   bk_d.rx  = frm_word[DIV_W-1:0];
                SP_REF: begin
                    bk_d.sel = frm_word[13:12];
                    bk_d.rf  = frm_word[REFDIV_W-1:0];
                end
                SP_TX:   bk_d.tx  = frm_word[DIV_W-1:0];
            endcase
        end
        if (hi_ok) begin
            bk_d.thr = frm_word[THR_LSB +: THR_W];
            bk_d.cap = frm_word[CAP_LSB +: CAP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q     <= '0;
            bk_q.rx  <= DIV_W'(RX_DEF);
            bk_q.tx  <= DIV_W'(TX_DEF);
            bk_q.rf  <= REFDIV_W'(REF_DEF);
        end else begin
            bk_q <= bk_d;
        end
    end

    assign rx_ratio  = bk_q.rx;
    assign tx_ratio  = bk_q.tx;
    assign ref_ratio = bk_q.rf;
    assign ref_sel   = bk_q.sel;
    assign ctrl      = bk_q.ctl;
    assign cap_trim  = bk_q.cap;
    assign thr_code  = bk_q.thr;

    // R8: a low-space frame of the wrong length leaves the low-space registers alone
    assert_bad_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && !frm_hi && (frm_len != LEN_LONG)) |=>
        ($stable(bk_q.rx) && $stable(bk_q.tx) && $stable(bk_q.rf) &&
         $stable(bk_q.sel) && $stable(bk_q.ctl)));

    // R6: a high-space frame whose leading bit is 0 is ignored
    assert_mode_zero_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_hi && !lead_bit) |=> ($stable(bk_q.cap) && $stable(bk_q.thr)));

    // R10: a high-space frame never disturbs the dividers or the control word
    assert_hi_keeps_dividers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_hi) |=>
        ($stable(bk_q.rx) && $stable(bk_q.tx) && $stable(bk_q.rf) && $stable(bk_q.ctl)));

    // R3: no register moves without a closed frame
    assert_no_spurious_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(bk_q));

endmodule

// File: rtl/serial_prog_status.sv
// Routes the shared status output and decodes the battery threshold.
module serial_prog_status
    import serial_prog_pkg::*;
(
    input  ctrl_t            ctrl,
    input  logic [THR_W-1:0] thr_code,
    input  logic             carrier_det,
    input  logic             lock_det,
    input  logic             ref_test,
    input  logic             rx_loop_tst,
    input  logic             tx_loop_tst,
    output logic             status_out,
    output logic [MV_W-1:0]  thr_mv
);

    localparam logic [MV_W-1:0] MV_TOP = MV_W'(3450);
    localparam logic [MV_W-1:0] MV_LOW = MV_W'(2100);

    always_comb begin
        unique case (ctrl.test)
            2'b00: status_out = ctrl.stat_sel ? lock_det : carrier_det;
            2'b01: status_out = ref_test;
            2'b10: status_out = rx_loop_tst;
            default: status_out = tx_loop_tst;
        endcase
    end

    always_comb begin
        case (thr_code)
            4'b1011: thr_mv = MV_W'(3300);
            4'b1101: thr_mv = MV_W'(3000);
            4'b0111: thr_mv = MV_W'(2200);
            4'b1111: thr_mv = MV_LOW;
            default: thr_mv = MV_TOP;
        endcase
    end

    // R7: decoded threshold always lies inside the supported window
    always_comb begin
        if (!$isunknown(thr_code)) begin
            assert_thr_range_R7: assert ((thr_mv >= MV_LOW) && (thr_mv <= MV_TOP));
        end
    end

endmodule

// File: rtl/serial_prog_bank.sv
module serial_prog_bank
    import serial_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 5,
    parameter int RX_DEF      = 7215,
    parameter int TX_DEF      = 9966,
    parameter int REF_DEF     = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_dat,
    input  logic                ser_en,
    input  logic                carrier_det,
    input  logic                lock_det,
    input  logic                ref_test,
    input  logic                rx_loop_tst,
    input  logic                tx_loop_tst,
    output logic [DIV_W-1:0]    rx_ratio,
    output logic [DIV_W-1:0]    tx_ratio,
    output logic [REFDIV_W-1:0] ref_ratio,
    output logic [1:0]          ref_post_sel,
    output logic                tx_pll_off,
    output logic                comp_mute,
    output logic                comp_off,
    output logic                exp_mute,
    output logic                exp_off,
    output logic                batt_off,
    output logic                rx_off,
    output logic [CAP_W-1:0]    cap_trim,
    output logic [THR_W-1:0]    thr_code,
    output logic [MV_W-1:0]     thr_mv,
    output logic                status_out
);

    logic              frm_vld, frm_hi;
    logic [CNT_W-1:0]  frm_len;
    logic [WORD_W-1:0] frm_word;
    ctrl_t             ctrl;

    serial_prog_frontend #(
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (CNT_W)
    ) frontend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .ser_en   (ser_en),
        .frm_vld  (frm_vld),
        .frm_hi   (frm_hi),
        .frm_len  (frm_len),
        .frm_word (frm_word)
    );

    serial_prog_regbank #(
        .CNT_W   (CNT_W),
        .RX_DEF  (RX_DEF),
        .TX_DEF  (TX_DEF),
        .REF_DEF (REF_DEF)
    ) regbank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_vld   (frm_vld),
        .frm_hi    (frm_hi),
        .frm_len   (frm_len),
        .frm_word  (frm_word),
        .rx_ratio  (rx_ratio),
        .tx_ratio  (tx_ratio),
        .ref_ratio (ref_ratio),
        .ref_sel   (ref_post_sel),
        .ctrl      (ctrl),
        .cap_trim  (cap_trim),
        .thr_code  (thr_code)
    );

    serial_prog_status status_i (
        .ctrl        (ctrl),
        .thr_code    (thr_code),
        .carrier_det (carrier_det),
        .lock_det    (lock_det),
        .ref_test    (ref_test),
        .rx_loop_tst (rx_loop_tst),
        .tx_loop_tst (tx_loop_tst),
        .status_out  (status_out),
        .thr_mv      (thr_mv)
    );

    assign tx_pll_off = ctrl.tx_pll_off;
    assign comp_mute  = ctrl.comp_mute;
    assign comp_off   = ctrl.comp_off;
    assign exp_mute   = ctrl.exp_mute;
    assign exp_off    = ctrl.exp_off;
    assign batt_off   = ctrl.batt_off;
    assign rx_off     = ctrl.rx_off;

endmodule

// File: tb/serial_prog_bank_tb_top.sv
module serial_prog_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    // {enable level, frame length, frame word}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 5'd16, 16'h44D2},  // receive ratio 1234
        {1'b0, 5'd16, 16'hC010},  // transmit ratio 16
        {1'b0, 5'd16, 16'hAFFF},  // reference sel 2, ratio 4095
        {1'b0, 5'd16, 16'h2482},  // control word
        {1'b1, 5'd12, 16'h0AED},  // short high frame, thr 1011 trim 45
        {1'b1, 5'd16, 16'hFFFF},  // long high frame, all ones
        {1'b1, 5'd12, 16'h09C1},  // thr 0111 trim 1
        {1'b0, 5'd16, 16'h1A61},  // control word
        {1'b0, 5'd12, 16'h4123},  // short low frame: dropped
        {1'b1, 5'd16, 16'h03FF},  // leading bit 0: dropped
        {1'b1, 5'd14, 16'h3FFF},  // odd length: dropped
        {1'b0, 5'd16, 16'h7FFF},  // receive ratio max
        {1'b1, 5'd12, 16'h0B40},  // thr 1101 trim 0
        {1'b1, 5'd12, 16'h0847}   // thr 0001 trim 7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
    logic carrier_det = 1'b1, lock_det = 1'b0, ref_test = 1'b1;
    logic rx_loop_tst = 1'b0, tx_loop_tst = 1'b1;
    logic [13:0] rx_ratio, tx_ratio;
    logic [11:0] ref_ratio, thr_mv;
    logic [1:0]  ref_post_sel;
    logic tx_pll_off, comp_mute, comp_off, exp_mute, exp_off, batt_off, rx_off;
    logic [5:0] cap_trim;
    logic [3:0] thr_code;
    logic status_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model state
    int exp_rx = 7215, exp_tx = 9966, exp_ref = 2048, exp_sel = 0;
    logic [6:0] exp_ctl = '0;
    logic       exp_ssel = 1'b0;
    logic [1:0] exp_test = 2'b00;
    int exp_cap = 0, exp_thr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_prog_bank dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .carrier_det(carrier_det), .lock_det(lock_det), .ref_test(ref_test),
        .rx_loop_tst(rx_loop_tst), .tx_loop_tst(tx_loop_tst),
        .rx_ratio(rx_ratio), .tx_ratio(tx_ratio), .ref_ratio(ref_ratio),
        .ref_post_sel(ref_post_sel), .tx_pll_off(tx_pll_off), .comp_mute(comp_mute),
        .comp_off(comp_off), .exp_mute(exp_mute), .exp_off(exp_off), .batt_off(batt_off),
        .rx_off(rx_off), .cap_trim(cap_trim), .thr_code(thr_code), .thr_mv(thr_mv),
        .status_out(status_out)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int mv_of(input int code);
        case (code)
            11: return 3300;
            13: return 3000;
            7:  return 2200;
            15: return 2100;
            default: return 3450;
        endcase
    endfunction

    function automatic logic route(input logic [1:0] t, input logic s);
        case (t)
            2'b00: return s ? lock_det : carrier_det;
            2'b01: return ref_test;
            2'b10: return rx_loop_tst;
            default: return tx_loop_tst;
        endcase
    endfunction

    task automatic model(input logic en, input int len, input logic [15:0] w);
        if (!en && len == 16) begin
            case (w[15:14])
                2'b00: begin
                    exp_ctl  = {w[13], w[12], w[11], w[10], w[9], w[6], w[5]};
                    exp_ssel = w[7];
                    exp_test = w[1:0];
                end
                2'b01: exp_rx = int'(w[13:0]);
                2'b10: begin exp_sel = int'(w[13:12]); exp_ref = int'(w[11:0]); end
                default: exp_tx = int'(w[13:0]);
            endcase
        end
        if (en && (len == 12 || len == 16) && w[len-1]) begin
            exp_thr = int'(w[9:6]);
            exp_cap = int'(w[5:0]);
        end
    endtask

    task automatic check_all(input string ctx);
        @(negedge clk);
        chk({ctx, " R3 rx"}, int'(rx_ratio), exp_rx);
        chk({ctx, " R3 tx"}, int'(tx_ratio), exp_tx);
        chk({ctx, " R3 ref"}, int'(ref_ratio), exp_ref);
        chk({ctx, " R3 sel"}, int'(ref_post_sel), exp_sel);
        chk({ctx, " R4 ctrl"},
            int'({tx_pll_off, comp_mute, comp_off, exp_mute, exp_off, batt_off, rx_off}),
            int'(exp_ctl));
        chk({ctx, " R5 cap"}, int'(cap_trim), exp_cap);
        chk({ctx, " R5 thr"}, int'(thr_code), exp_thr);
        chk({ctx, " R7 mv"}, int'(thr_mv), mv_of(exp_thr));
        chk({ctx, " R9 status"}, int'(status_out), int'(route(exp_test, exp_ssel)));
    endtask

    // R2: bits go out MSB first, one per serial clock rise; enable toggle closes
    task automatic send_frame(input logic en, input int len, input logic [15:0] w);
        @(negedge clk);
        if (ser_en !== en) begin
            ser_en = en;
            repeat (8) @(negedge clk);
        end
        for (int i = len - 1; i >= 0; i--) begin
            ser_dat = (i < 16) ? w[i] : 1'b0;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_en = ~en;
        repeat (20) @(negedge clk);
        model(en, len, w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 reset");

        for (int v = 0; v < NVEC; v++) begin
            logic en;
            int len;
            logic [15:0] w;
            string ctx;
            en  = VEC[v][21];
            len = int'(VEC[v][20:16]);
            w   = VEC[v][15:0];
            if ((!en && len != 16) || (en && len != 12 && len != 16)) ctx = "R8 drop";
            else if (en && !w[len-1]) ctx = "R6 lead0";
            else ctx = "R2 R10 frame";
            send_frame(en, len, w);
            check_all(ctx);
        end

        // R8: a 20-bit low frame must be dropped even though its tail fits
        send_frame(1'b0, 20, 16'h4111);
        check_all("R8 long");

        // R9: every route with two input patterns
        for (int c = 0; c < 5; c++) begin
            logic [15:0] w;
            case (c)
                0: w = 16'h0000;
                1: w = 16'h0080;
                2: w = 16'h0001;
                3: w = 16'h0002;
                default: w = 16'h0003;
            endcase
            send_frame(1'b0, 16, w);
            check_all("R9 route");
            @(negedge clk);
            carrier_det = ~carrier_det; lock_det = ~lock_det; ref_test = ~ref_test;
            rx_loop_tst = ~rx_loop_tst; tx_loop_tst = ~tx_loop_tst;
            check_all("R9 route flip");
        end

        // R1: a second reset restores all defaults
        @(negedge clk);
        rst_n = 1'b0;
        ser_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_rx = 7215; exp_tx = 9966; exp_ref = 2048; exp_sel = 0;
        exp_ctl = '0; exp_ssel = 1'b0; exp_test = 2'b00; exp_cap = 0; exp_thr = 0;
        repeat (2) @(negedge clk);
        check_all("R1 rereset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule